// File: doc/BRIEF.md
# Back-Porch Clamp Pulse Generator

This block drives the clamp-enable used by three video input channels to restore their black level. In internal mode it watches the incoming horizontal sync and finds the edge that ends each sync pulse. A polarity bit decides whether that edge is falling or rising. The block then waits a programmed number of pixel clocks and holds the clamp for another programmed number of pixel clocks, so the pulse lands on the back porch.

In external mode the internal timer is bypassed. An external clamp pin drives the output after its polarity has been normalised, and the placement and length settings are disregarded. Both asynchronous inputs pass through a two-flop synchroniser. The output is one registered, active-high signal in both modes.

Top module: `clampgen_top`

## Requirements
- R1: While reset is held, and afterwards until a trailing sync edge is detected, `clamp_en` is 0.
- R2: With `hs_pol_high`=1 the falling edge of `hsync_in` is the trailing edge that starts a clamp sequence; a rising edge starts nothing and leaves `clamp_en` at 0.
- R3: With `hs_pol_high`=0 the rising edge of `hsync_in` is the trailing edge; a falling edge starts nothing.
- R4: With `ext_sel`=0, let k be the first clock edge that samples the new `hsync_in` level of a trailing edge. `clamp_en` goes to 1 after edge k+3+P, where P is `clamp_place`.
- R5: `clamp_en` then stays 1 for exactly L clock cycles, where L is `clamp_len`, and is 0 after edge k+3+P+L.
- R6: A `clamp_place` of 0 acts as 1, and a `clamp_len` of 0 acts as 1.
- R7: A trailing edge detected while a placement or length count is running restarts the sequence from the new edge. The timing of the earlier edge is abandoned, even when the new edge coincides with the last clamp cycle.
- R8: With `ext_sel`=1, let k be the first edge that samples a new `ext_clamp_in` level. After edge k+2, `clamp_en` equals the inverse of that level when `ext_pol_low`=1 and equals the level itself when `ext_pol_low`=0.
- R9: With `ext_sel`=1, `hsync_in`, `clamp_place` and `clamp_len` have no effect on `clamp_en`.
- R10: With `ext_sel`=0, `ext_clamp_in` and `ext_pol_low` have no effect on `clamp_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Raw horizontal sync, asynchronous |
| hs_pol_high | input | 1 | 1: sync active high (trailing edge falls); 0: active low |
| clamp_place | input | CNT_W | Pixel clocks from trailing edge to clamp start |
| clamp_len | input | CNT_W | Clamp length in pixel clocks |
| ext_sel | input | 1 | 0: internal timer; 1: external clamp pin |
| ext_clamp_in | input | 1 | External clamp pin, asynchronous |
| ext_pol_low | input | 1 | 1: external pin active low; 0: active high |
| clamp_en | output | 1 | Registered active-high clamp enable |

## Verification
The two functions that can fall in the same cycle are the end of a running clamp and the restart caused by a new trailing edge. The bench times a second sync pulse so that its trailing edge is detected exactly on the edge where the length count reaches its last cycle. It then requires the restart to win, so the new placement window is seen in full. Restarts in the middle of the placement wait and in the middle of the clamp are also provoked. Every cycle is compared against a bench function that computes the window from the newest trailing edge.

// File: rtl/clampgen_pkg.sv
package clampgen_pkg;
  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_WAIT = 2'd1,
    TS_ON   = 2'd2
  } tmr_state_e;
endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stg
      logic [W-1:0] r;
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) r <= '0;
          else     r <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) r <= '0;
          else     r <= g_stg[gi-1].r;
        end
      end
    end
  endgenerate

  assign q = g_stg[STAGES-1].r;
endmodule

// File: rtl/cg_trail.sv
module cg_trail (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic act_high,
  output logic trail
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  always_comb begin
    if (act_high) trail = prev_q & ~lvl;
    else          trail = ~prev_q & lvl;
  end

  // R2
  trail_level_chk: assert property (@(posedge clk) disable iff (rst)
    trail |-> (lvl != act_high));
endmodule

// File: rtl/cg_timer.sv
module cg_timer
  import clampgen_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trail,
  input  logic [CNT_W-1:0] place,
  input  logic [CNT_W-1:0] len,
  output logic             busy_on
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  tmr_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] place_eff;
  logic [CNT_W-1:0] len_eff;

  always_comb begin
    place_eff = (place == '0) ? ONE : place;
    len_eff   = (len == '0) ? ONE : len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= TS_IDLE;
      cnt <= '0;
    end else if (trail) begin
      st  <= TS_WAIT;
      cnt <= place_eff;
    end else begin
      case (st)
        TS_WAIT: begin
          if (cnt == ONE) begin
            st  <= TS_ON;
            cnt <= len_eff;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        TS_ON: begin
          if (cnt == ONE) begin
            st  <= TS_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        default: begin
          st  <= TS_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end

  assign busy_on = (st == TS_ON);

  // R6
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (st != TS_IDLE) |-> (cnt != '0));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    trail |=> (st == TS_WAIT && !busy_on));

  // R4
  wait_step_chk: assert property (@(posedge clk) disable iff (rst)
    (st == TS_WAIT && cnt != ONE && !trail) |=>
      (st == TS_WAIT && cnt == $past(cnt) - ONE));

  // R5
  on_end_chk: assert property (@(posedge clk) disable iff (rst)
    (st == TS_ON && cnt == ONE && !trail) |=> (st == TS_IDLE));
endmodule

// File: rtl/clampgen_top.sv
module clampgen_top #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hsync_in,
  input  logic             hs_pol_high,
  input  logic [CNT_W-1:0] clamp_place,
  input  logic [CNT_W-1:0] clamp_len,
  input  logic             ext_sel,
  input  logic             ext_clamp_in,
  input  logic             ext_pol_low,
  output logic             clamp_en
);
  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0] sync_q;
  logic              trail_pulse;
  logic              tmr_on;
  logic              ext_level;

  cg_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ext_clamp_in, hsync_in}),
    .q   (sync_q)
  );

  cg_trail u_trail (
    .clk      (clk),
    .rst      (rst),
    .lvl      (sync_q[0]),
    .act_high (hs_pol_high),
    .trail    (trail_pulse)
  );

  cg_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .trail   (trail_pulse),
    .place   (clamp_place),
    .len     (clamp_len),
    .busy_on (tmr_on)
  );

  assign ext_level = sync_q[1] ^ ext_pol_low;

  always_ff @(posedge clk) begin
    if (rst)          clamp_en <= 1'b0;
    else if (ext_sel) clamp_en <= ext_level;
    else              clamp_en <= tmr_on;
  end

  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (rst)                warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R8
  ext_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (warm_q == 2'd3 && $past(ext_sel)) |->
      (clamp_en == ($past(ext_clamp_in, 3) ^ $past(ext_pol_low))));

  // R1
  reset_low_chk: assert property (@(posedge clk)
    $past(rst) |-> !clamp_en);
endmodule

// File: tb/tb_clampgen_top.sv
`timescale 1ns/1ps
module tb_clampgen_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       hsync_in;
  logic       hs_pol_high;
  logic [7:0] clamp_place;
  logic [7:0] clamp_len;
  logic       ext_sel;
  logic       ext_clamp_in;
  logic       ext_pol_low;
  logic       clamp_en;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #2.5 clk = ~clk;

  clampgen_top dut (
    .clk          (clk),
    .rst          (rst),
    .hsync_in     (hsync_in),
    .hs_pol_high  (hs_pol_high),
    .clamp_place  (clamp_place),
    .clamp_len    (clamp_len),
    .ext_sel      (ext_sel),
    .ext_clamp_in (ext_clamp_in),
    .ext_pol_low  (ext_pol_low),
    .clamp_en     (clamp_en)
  );

  function automatic bit exp_clamp(int m, int p, int d);
    int pe = (p == 0) ? 1 : p;
    int de = (d == 0) ? 1 : d;
    return (m >= 3 + pe) && (m < 3 + pe + de);
  endfunction

  task automatic chk(bit act, bit exp, string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: clamp_en=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_seq(int p, int d, int mfrom, string req);
    int pe = (p == 0) ? 1 : p;
    int de = (d == 0) ? 1 : d;
    for (int m = 0; m <= 4 + pe + de; m++) begin
      tick();
      if (m >= mfrom) chk(clamp_en, exp_clamp(m, p, d), req);
    end
  endtask

  task automatic line(int p, int d, int lead, string req);
    clamp_place = 8'(p);
    clamp_len   = 8'(d);
    hsync_in    = hs_pol_high;
    for (int i = 0; i < lead; i++) begin
      tick();
      chk(clamp_en, 1'b0, hs_pol_high ? "R2 leading edge ignored" : "R3 leading edge ignored");
    end
    hsync_in = ~hs_pol_high;
    check_seq(p, d, 0, req);
  endtask

  task automatic set_pol(bit ah);
    hs_pol_high = ah;
    hsync_in    = ~ah;
    repeat (600) tick();
  endtask

  task automatic retrig(int p, int d, int gap, string req);
    clamp_place = 8'(p);
    clamp_len   = 8'(d);
    hsync_in    = hs_pol_high;
    repeat (3) tick();
    hsync_in = ~hs_pol_high;
    for (int m = 0; m < gap; m++) begin
      tick();
      chk(clamp_en, exp_clamp(m, p, d), req);
      if (m == gap - 3) hsync_in = hs_pol_high;
      if (m == gap - 1) hsync_in = ~hs_pol_high;
    end
    check_seq(p, d, 3, req);
  endtask

  task automatic ext_run(bit pol, int n);
    bit p1 = 0, p2 = 0, p3 = 0;
    ext_pol_low = pol;
    ext_sel     = 1'b1;
    for (int i = 0; i < n; i++) begin
      tick();
      if (i >= 4) chk(clamp_en, p3 ^ pol, pol ? "R8 inverted pin / R9" : "R8 direct pin / R9");
      p3 = p2;
      p2 = p1;
      p1 = 1'($urandom_range(0, 1));
      ext_clamp_in = p1;
      hsync_in     = 1'($urandom_range(0, 1));
      clamp_place  = 8'($urandom_range(0, 255));
      clamp_len    = 8'($urandom_range(0, 255));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst          = 1'b1;
    hsync_in     = 1'b0;
    hs_pol_high  = 1'b1;
    clamp_place  = 8'd4;
    clamp_len    = 8'd3;
    ext_sel      = 1'b0;
    ext_clamp_in = 1'b0;
    ext_pol_low  = 1'b1;
    repeat (4) tick();
    chk(clamp_en, 1'b0, "R1 during reset");
    rst = 1'b0;
    for (int i = 0; i < 20; i++) begin
      tick();
      chk(clamp_en, 1'b0, "R1 idle after reset");
    end

    // R2 falling edge trails, rising ignored; R4/R5 basic window
    line(1, 1, 12, "R2/R4/R5 short pulse");
    line(5, 7, 4, "R4/R5 mid pulse");
    // R6 zero values act as one
    line(0, 0, 4, "R6 zero place and len");
    line(0, 9, 4, "R6 zero place");
    line(6, 0, 4, "R6 zero len");
    line(255, 255, 4, "R4/R5 full range");

    // R7 restarts: during wait, during clamp, on final clamp cycle
    retrig(10, 5, 5, "R7 restart in wait");
    retrig(2, 20, 8, "R7 restart in clamp");
    retrig(4, 6, 10, "R7 restart on last clamp cycle");

    // R3 active-low sync
    set_pol(1'b0);
    line(3, 4, 12, "R3 rising edge trails");
    retrig(6, 6, 12, "R3/R7 restart active low");
    set_pol(1'b1);

    // R10 random lines with external pin and polarity toggling
    for (int n = 0; n < 30; n++) begin
      if (n % 10 == 5) set_pol(~hs_pol_high);
      ext_clamp_in = 1'($urandom_range(0, 1));
      ext_pol_low  = 1'($urandom_range(0, 1));
      line($urandom_range(0, 40), $urandom_range(0, 40), $urandom_range(2, 6),
           "R4/R5/R10 random line");
    end

    // R8 and R9 external mode, both polarities
    ext_run(1'b1, 300);
    ext_run(1'b0, 300);
    ext_sel     = 1'b0;
    hs_pol_high = 1'b1;
    hsync_in    = 1'b0;
    repeat (600) tick();
    line(2, 3, 4, "R10 back to internal");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule